// File: doc/BRIEF.md
# Switch Debouncer with Separate Press and Release Hold Times

This block cleans up the level from one mechanical switch wired to ground with a pull-up, so that a low pin means the switch is closed. The raw pin first passes through a short flip-flop synchronizer. A built-in prescaler divides the clock into a slow periodic sample strobe. The decision logic looks at the synchronized level only on that strobe and ignores the input on every other clock edge.

On each strobe the sampled level is compared with a tracked candidate level. A mismatch makes the sample the new candidate and clears a steadiness counter. A match advances the counter, which stops at the larger of the two hold times. Once a low candidate has matched for the press hold time, the debounced output goes to pressed. Once a high candidate has matched for the release hold time, the output goes back to released. Each accepted change raises a one-clock event flag. Setting the two hold times apart lets a press be accepted quickly while a release needs a longer quiet interval. That gives stronger noise rejection once the switch is open.

Top module: `switch_debounce`

## Requirements
- R1: While reset is high and in the first cycle after it, `pressed` is 0 and `changed` is 0. Reset makes the candidate level high and clears the counter.
- R2: The raw pin passes through SYNC_STAGES flip-flops, reset to 1, before the decision logic sees it. A level applied before clock edge e is first visible to the decision logic at edge e+SYNC_STAGES.
- R3: The sample strobe is high for one clock in every TICK_DIV clocks. The first strobe comes TICK_DIV-1 edges after reset is released. `pressed` and `changed` can change only in the clock that follows a strobe, and input activity between strobes has no effect.
- R4: When a strobe sample differs from the candidate level, that sample becomes the candidate and the steadiness count restarts from zero. A bounce shorter than the hold time therefore never changes `pressed`.
- R5: A press is accepted on the strobe where a low candidate has matched on PRESS_TICKS consecutive strobes after the strobe that first saw it.
- R6: A release is accepted on the strobe where a high candidate has matched on RELEASE_TICKS consecutive strobes after the strobe that first saw it. A high spell shorter than that leaves `pressed` at 1.
- R7: `changed` is high for exactly one clock. That is the first clock in which `pressed` shows its new value, and `pressed` never changes without it.
- R8: The switch is active low. `pressed`=1 means a low pin level was accepted, and `pressed`=0 means a high pin level was accepted.
- R9: The steadiness counter stops at max(PRESS_TICKS, RELEASE_TICKS) and never wraps. After an arbitrarily long steady interval, the next press is still accepted with the normal latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sw_raw_n | input | 1 | Raw switch pin, asynchronous; low means closed |
| pressed | output | 1 | Debounced switch state, 1 = closed |
| changed | output | 1 | One-clock pulse when `pressed` takes a new value |

## Verification
On every clock the embedded properties check several things. The counter never exceeds its ceiling. Events occur only right after a strobe, and strobes are isolated single cycles. Each event is a single cycle that matches a toggle of `pressed`. Each accepted press or release follows a counter history long enough for its own hold time, in the pin direction the event claims. What the properties cannot see is end-to-end timing. The exact latency window from a pin edge to the event, the rejection of one-cycle glitches and of bounce trains shorter than a hold time, and the normal response after a long saturated interval are shown by the bench scenarios. In those scenarios a behavioural model is compared against the outputs on every clock.

// File: rtl/swdb_pkg.sv
package swdb_pkg;

    // Level of the switch pin as seen by the decision logic.
    typedef enum logic {
        PIN_LOW  = 1'b0,
        PIN_HIGH = 1'b1
    } pin_lvl_e;

    // Registered decision state: candidate level and accepted output.
    typedef struct packed {
        pin_lvl_e track;
        logic     pressed;
    } swdb_state_t;

    function automatic int unsigned max_of(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    // Bits needed to hold the value v (at least one).
    function automatic int unsigned width_for(input int unsigned v);
        return (v < 2) ? 1 : $clog2(v + 1);
    endfunction

endpackage

// File: rtl/swdb_sync.sv
module swdb_sync #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic raw_i,
    output logic lvl_o
);
    logic [SYNC_STAGES-1:0] stage_q;

    // Each stage resets to the released (high) level.
    for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stage_q[g] <= 1'b1;
                else     stage_q[g] <= raw_i;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) stage_q[g] <= 1'b1;
                else     stage_q[g] <= stage_q[g-1];
            end
        end
    end

    assign lvl_o = stage_q[SYNC_STAGES-1];

endmodule

// File: rtl/swdb_tick_gen.sv
module swdb_tick_gen
    import swdb_pkg::*;
#(
    parameter int unsigned TICK_DIV = 625000
) (
    input  logic clk,
    input  logic rst,
    output logic tick_o
);
    localparam int unsigned DIV_W = width_for(TICK_DIV - 1);
    localparam logic [DIV_W-1:0] LAST = DIV_W'(TICK_DIV - 1);

    logic [DIV_W-1:0] div_q;

    always_ff @(posedge clk) begin
        if (rst)                div_q <= '0;
        else if (div_q == LAST) div_q <= '0;
        else                    div_q <= div_q + 1'b1;
    end

    assign tick_o = (div_q == LAST);

    // R3: a strobe lasts one clock and is never followed by another at once
    p_tick_gap_r3: assert property (@(posedge clk) disable iff (rst)
        tick_o |=> !tick_o);

    // R3: the divider never passes its last value
    p_div_range_r3: assert property (@(posedge clk) disable iff (rst)
        div_q <= LAST);

endmodule

// File: rtl/swdb_fsm.sv
module swdb_fsm
    import swdb_pkg::*;
#(
    parameter int unsigned PRESS_TICKS   = 4,
    parameter int unsigned RELEASE_TICKS = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic tick_i,
    input  logic lvl_i,
    output logic pressed_o,
    output logic changed_o
);
    localparam int unsigned SAT   = max_of(PRESS_TICKS, RELEASE_TICKS);
    localparam int unsigned CNT_W = width_for(SAT);
    localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(SAT);
    localparam logic [CNT_W-1:0] NEED_PRS = CNT_W'(PRESS_TICKS);
    localparam logic [CNT_W-1:0] NEED_REL = CNT_W'(RELEASE_TICKS);

    swdb_state_t      st_q;
    logic [CNT_W-1:0] cnt_q;
    logic             chg_q;

    logic [CNT_W-1:0] cnt_inc;
    logic [CNT_W-1:0] need;
    logic             same;
    logic             want_press;
    logic             confirm;

    always_comb begin
        cnt_inc    = (cnt_q == CNT_SAT) ? cnt_q : cnt_q + 1'b1;
        want_press = (st_q.track == PIN_LOW);
        need       = want_press ? NEED_PRS : NEED_REL;
        same       = (lvl_i == st_q.track);
        confirm    = tick_i && same && (cnt_inc >= need)
                     && (want_press != st_q.pressed);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.track   <= PIN_HIGH;
            st_q.pressed <= 1'b0;
            cnt_q        <= '0;
            chg_q        <= 1'b0;
        end else begin
            chg_q <= confirm;
            if (tick_i) begin
                if (!same) begin
                    st_q.track <= pin_lvl_e'(lvl_i);
                    cnt_q      <= '0;
                end else begin
                    cnt_q <= cnt_inc;
                end
                if (confirm) st_q.pressed <= want_press;
            end
        end
    end

    assign pressed_o = st_q.pressed;
    assign changed_o = chg_q;

    // R9: the steadiness counter stays at or below its ceiling
    p_cnt_sat_r9: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CNT_SAT);

    // R3: an event can only follow a sample strobe
    p_event_after_tick_r3: assert property (@(posedge clk) disable iff (rst)
        changed_o |-> $past(tick_i));

    // R7: every toggle of the output carries the event flag
    p_toggle_flagged_r7: assert property (@(posedge clk) disable iff (rst)
        (pressed_o != $past(pressed_o)) |-> changed_o);

    // R7: the event flag is a single clock wide
    p_event_single_r7: assert property (@(posedge clk) disable iff (rst)
        changed_o |=> !changed_o);

    // R5: an accepted press needs a long enough low history
    p_press_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (changed_o && pressed_o) |-> ($past(cnt_q) >= NEED_PRS - 1'b1));

    // R6: an accepted release needs a long enough high history
    p_release_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (changed_o && !pressed_o) |-> ($past(cnt_q) >= NEED_REL - 1'b1));

    // R8: a press follows a low sample, a release a high sample
    p_polarity_r8: assert property (@(posedge clk) disable iff (rst)
        changed_o |-> ($past(lvl_i) == !pressed_o));

endmodule

// File: rtl/switch_debounce.sv
module switch_debounce
    import swdb_pkg::*;
#(
    parameter int unsigned TICK_DIV      = 625000,
    parameter int unsigned PRESS_TICKS   = 4,
    parameter int unsigned RELEASE_TICKS = 8,
    parameter int unsigned SYNC_STAGES   = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic sw_raw_n,
    output logic pressed,
    output logic changed
);
    logic lvl_sync;
    logic tick;

    swdb_sync #(.SYNC_STAGES(SYNC_STAGES)) sync_i (
        .clk   (clk),
        .rst   (rst),
        .raw_i (sw_raw_n),
        .lvl_o (lvl_sync)
    );

    swdb_tick_gen #(.TICK_DIV(TICK_DIV)) tick_i (
        .clk    (clk),
        .rst    (rst),
        .tick_o (tick)
    );

    swdb_fsm #(
        .PRESS_TICKS   (PRESS_TICKS),
        .RELEASE_TICKS (RELEASE_TICKS)
    ) fsm_i (
        .clk       (clk),
        .rst       (rst),
        .tick_i    (tick),
        .lvl_i     (lvl_sync),
        .pressed_o (pressed),
        .changed_o (changed)
    );

    // R1: nothing is reported in the first clock after reset
    p_reset_quiet_r1: assert property (@(posedge clk)
        $past(rst) |-> (!pressed && !changed));

endmodule

// File: tb/switch_debounce_tb_top.sv
module switch_debounce_tb_top;

    localparam int DIV = 4;
    localparam int PRS = 3;
    localparam int REL = 6;
    localparam int SAT = (PRS > REL) ? PRS : REL;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic raw = 1'b1;
    logic pressed;
    logic changed;

    int n_checks = 0;
    int n_fail   = 0;
    int ev_cnt   = 0;
    bit done     = 0;
    bit cmp_on   = 0;

    always #4 clk = ~clk;  // 125 MHz

    switch_debounce #(
        .TICK_DIV      (DIV),
        .PRESS_TICKS   (PRS),
        .RELEASE_TICKS (REL),
        .SYNC_STAGES   (2)
    ) dut_i (
        .clk      (clk),
        .rst      (rst),
        .sw_raw_n (raw),
        .pressed  (pressed),
        .changed  (changed)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic chk_range(input string tag, input int act, input int lo, input int hi);
        n_checks++;
        if (act < lo || act > hi) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d..%0d", tag, act, lo, hi);
        end
    endtask

    // Behavioural reference: pin delay line, strobe phase, candidate and counter.
    int pipe[$] = '{1, 1};
    int m_phase = 0;
    int m_track = 1;
    int m_cnt   = 0;
    int m_press = 0;
    int m_chg   = 0;

    always @(posedge clk) begin
        if (changed) ev_cnt++;
        if (rst) begin
            pipe    = '{1, 1};
            m_phase = 0;
            m_track = 1;
            m_cnt   = 0;
            m_press = 0;
            m_chg   = 0;
        end else begin
            int seen;
            int need;
            seen  = pipe[0];
            m_chg = 0;
            if (m_phase == DIV - 1) begin
                if (seen != m_track) begin
                    m_track = seen;
                    m_cnt   = 0;
                end else begin
                    if (m_cnt < SAT) m_cnt++;
                    need = (m_track == 0) ? PRS : REL;
                    if (m_cnt >= need && ((m_track == 0) ? 1 : 0) != m_press) begin
                        m_press = (m_track == 0) ? 1 : 0;
                        m_chg   = 1;
                    end
                end
                m_phase = 0;
            end else begin
                m_phase++;
            end
            pipe.push_back(int'(raw));
            void'(pipe.pop_front());
        end
    end

    always @(negedge clk) begin
        if (cmp_on) begin
            chk("R5 R6 R8 pressed vs model", int'(pressed), m_press);
            chk("R3 R7 changed vs model", int'(changed), m_chg);
        end
    end

    task automatic hold(input logic v, input int n);
        raw = v;
        repeat (n) @(negedge clk);
    endtask

    task automatic measure(input logic v, input int limit, output int n);
        raw = v;
        n = 0;
        while (n < limit) begin
            @(negedge clk);
            n++;
            if (changed) break;
        end
    endtask

    initial begin
        int e0;
        int lat;
        repeat (3) @(negedge clk);
        chk("R1 pressed in reset", int'(pressed), 0);
        chk("R1 changed in reset", int'(changed), 0);
        rst = 1'b0;
        cmp_on = 1;
        @(negedge clk);
        chk("R1 pressed after reset", int'(pressed), 0);
        chk("R1 changed after reset", int'(changed), 0);
        hold(1'b1, 20);
        chk("R1 no event while idle", ev_cnt, 0);

        // R3: a one-clock glitch cannot be accepted
        hold(1'b0, 1);
        hold(1'b1, 40);
        chk("R3 glitch ignored pressed", int'(pressed), 0);
        chk("R3 glitch ignored events", ev_cnt, 0);

        // R4: bounce train with low spells shorter than the press hold
        for (int i = 0; i < 5; i++) begin
            hold(1'b0, 2 * DIV);
            hold(1'b1, DIV);
        end
        hold(1'b1, 40);
        chk("R4 bounce rejected pressed", int'(pressed), 0);
        chk("R4 bounce rejected events", ev_cnt, 0);

        // R5 R2: press latency window and polarity (R8)
        e0 = ev_cnt;
        measure(1'b0, 100, lat);
        chk_range("R5 R2 press latency", lat, 3 + PRS * DIV, 2 + (PRS + 1) * DIV);
        chk("R8 low pin gives pressed", int'(pressed), 1);
        hold(1'b0, 10);
        chk("R7 single event for press", ev_cnt - e0, 1);

        // R6: short high spell does not release
        e0 = ev_cnt;
        hold(1'b1, 4 * DIV);
        hold(1'b0, 40);
        chk("R6 short release ignored", int'(pressed), 1);
        chk("R6 short release no event", ev_cnt - e0, 0);

        // R6: full release latency window
        e0 = ev_cnt;
        measure(1'b1, 100, lat);
        chk_range("R6 release latency", lat, 3 + REL * DIV, 2 + (REL + 1) * DIV);
        chk("R8 high pin gives released", int'(pressed), 0);
        hold(1'b1, 10);
        chk("R7 single event for release", ev_cnt - e0, 1);

        // R9: long steady high, then a normal press
        hold(1'b1, 400);
        e0 = ev_cnt;
        measure(1'b0, 100, lat);
        chk_range("R9 press after long idle", lat, 3 + PRS * DIV, 2 + (PRS + 1) * DIV);
        hold(1'b0, 400);
        chk("R9 long hold stays pressed", int'(pressed), 1);
        chk("R9 long hold one event", ev_cnt - e0, 1);
        measure(1'b1, 100, lat);
        chk_range("R9 release after long hold", lat, 3 + REL * DIV, 2 + (REL + 1) * DIV);
        hold(1'b1, 20);

        // R1: reset in the middle of a press
        hold(1'b0, 40);
        rst = 1'b1;
        cmp_on = 0;
        @(negedge clk);
        @(negedge clk);
        chk("R1 reset clears pressed", int'(pressed), 0);
        rst = 1'b0;
        cmp_on = 1;
        hold(1'b1, 40);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

endmodule